// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

This block moves received Ethernet frames into memory through a ring of receive descriptors. Frames arrive as a byte stream with a valid/ready handshake, a marker on the final byte, and a set of classification flags that are valid with that final byte. Before each frame the engine reads the current descriptor. A descriptor is 16 bytes long: the status word is at +0, the buffer capacity is at +4 and the buffer address is at +8. The engine then stores the frame bytes into that buffer and writes the status word back. The written status carries the stored length and the classification flags, and it returns ownership to software.

Software gives a descriptor to the engine by setting bit 31 of its status word. The engine clears that bit when it writes the status back. When the engine finds a descriptor that software still owns, it takes the next frame from the stream and discards all of it. It then reports a no-buffer event and keeps its ring position. A flag in the capacity word marks the last descriptor of the ring, and after it the engine returns to the ring base. The memory port is a single word port. A read returns its data one cycle after the request, and writes use per-byte lane enables.

Top module: `rxwb_engine`

## Requirements
- R1: While reset is asserted, `in_ready`, `rx_done` and `no_buf` are low, and the memory port presents a read of the ring base address (index 0).
- R2: After reset, the engine reads the status word at descriptor offset +0. Only if bit 31 of that word is set does it go on to read +4 and +8. `in_ready` rises on the fourth clock edge after reset is released.
- R3: Byte n of a frame is written with a single write to the word containing address buffer+n. Exactly one lane enable is set, equal to bit (buffer+n) mod 4, and the byte sits in that lane.
- R4: Only the first C bytes of a frame are stored, where C is bits [10:0] of descriptor word +4. The length written back saturates at C, and no byte beyond C reaches memory.
- R5: The write-back status word has bit 31 = 0, bit 29 = 1 (first segment), bit 28 = 1 (last segment), bits [10:0] = stored length, and all other bits outside [22:16] = 0.
- R6: Status bits [22:16] copy `in_flags[6:0]` as sampled with the final byte. The flag bits are: 0 = multicast, 1 = broadcast, 2 = general error, 3 = CRC error, 4 = too long, 5 = runt, 6 = odd nibble. Bit 20 is also set when bytes were discarded for lack of capacity.
- R7: `rx_done` pulses for exactly one cycle, in the cycle after the final byte of a stored frame is accepted. The status write happens in that same cycle.
- R8: A frame that meets a software-owned descriptor is accepted and discarded with no memory write. `no_buf` pulses for one cycle in the cycle after its final byte is accepted. The ring position is unchanged, so the next frame uses the same descriptor.
- R9: After a write-back the engine moves to the descriptor 16 bytes further on. If bit 31 of word +4 was set, it returns to the ring base instead.
- R10: `in_ready` is high only while a frame is being stored or discarded, and no memory read is issued while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | ADDR_W | Byte address of descriptor 0 |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final byte of the frame |
| in_flags | input | 7 | Frame classification, valid with the final byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| rx_done | output | 1 | Frame stored and status written |
| no_buf | output | 1 | Frame dropped because the descriptor was software-owned |

## Verification
The bench builds the engine with its default widths: a 32-bit address and an 8-bit ring index. It sets up a four-entry ring in a 1 KiB memory model. The buffers start at all four byte-lane offsets, and one buffer has a capacity of only 6 bytes. This brings truncation and the too-long flag within reach with short frames, while a 20-byte frame exactly fills its buffer. Five frames run the ring through its wrap. Descriptors are left unarmed on purpose so that two frames are dropped, and a re-armed descriptor catches the frame that follows.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

  // Length field width in the status and capacity words (format bound).
  localparam int LEN_W      = 11;
  localparam int FLAG_W     = 7;
  localparam int FLAG_LONG  = 4;
  localparam int FLAG_LSB   = 16;
  localparam int DESC_BYTES = 16;
  localparam int OWN_BIT    = 31;
  localparam int END_BIT    = 31;
  localparam int FIRST_BIT  = 29;
  localparam int LASTSEG_BIT = 28;

  typedef enum logic [2:0] {
    ST_FETCH_OWN,
    ST_CHECK_OWN,
    ST_LOAD_CAP,
    ST_LOAD_BUF,
    ST_STORE,
    ST_WRITEBACK,
    ST_DISCARD,
    ST_SKIP
  } rx_state_e;

  function automatic logic [31:0] status_word(input logic [LEN_W-1:0]  len,
                                              input logic [FLAG_W-1:0] flags,
                                              input logic              trunc);
    logic [31:0] w;
    w = '0;
    w[LEN_W-1:0] = len;
    w[FLAG_LSB +: FLAG_W] = flags;
    if (trunc) w[FLAG_LSB + FLAG_LONG] = 1'b1;
    w[FIRST_BIT]   = 1'b1;
    w[LASTSEG_BIT] = 1'b1;
    w[OWN_BIT]     = 1'b0;
    return w;
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] off);
    return 4'b0001 << off;
  endfunction

endpackage

// File: rtl/rxwb_ring_ptr.sv
module rxwb_ring_ptr
  import rxwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              step,
  input  logic              wrap,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int STRIDE_SH = $clog2(DESC_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (step)   idx <= wrap ? '0 : idx + 1'b1;
  end

  assign desc_addr = ring_base + (ADDR_W'(idx) << STRIDE_SH);

  // R9
  wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wrap) |=> (idx == '0));

  // R9
  advance_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wrap) |=> (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/rxwb_len_acc.sv
module rxwb_len_acc
  import rxwb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             byte_in,
  input  logic [LEN_W-1:0] cap,
  output logic [LEN_W-1:0] cnt,
  output logic             room,
  output logic             trunc
);
  assign room = (cnt < cap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      trunc <= 1'b0;
    end else if (clear) begin
      cnt   <= '0;
      trunc <= 1'b0;
    end else if (byte_in) begin
      if (room) cnt   <= cnt + 1'b1;
      else      trunc <= 1'b1;
    end
  end

  // R4
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_in |=> (cnt <= cap));

  // R4
  trunc_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_in && !room) |=> trunc);

endmodule

// File: rtl/rxwb_byte_lane.sv
module rxwb_byte_lane
  import rxwb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] buf_base,
  input  logic [LEN_W-1:0]  offset,
  input  logic [7:0]        data,
  output logic [ADDR_W-1:0] waddr,
  output logic [3:0]        be,
  output logic [31:0]       wdata
);
  logic [ADDR_W-1:0] baddr;

  assign baddr = buf_base + ADDR_W'(offset);
  assign waddr = {baddr[ADDR_W-1:2], 2'b00};
  assign be    = lane_mask(baddr[1:0]);

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign wdata[8*g +: 8] = be[g] ? data : 8'h00;
  end

endmodule

// File: rtl/rxwb_engine.sv
module rxwb_engine
  import rxwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [6:0]        in_flags,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              rx_done,
  output logic              no_buf
);
  localparam logic [ADDR_W-1:0] OFS_CAP = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_BUF = ADDR_W'(8);

  rx_state_e           state, nxt;
  logic [LEN_W-1:0]    cap_q;
  logic                end_q;
  logic [ADDR_W-1:0]   buf_q;
  logic [FLAG_W-1:0]   flags_q;

  // Named internal events
  logic                accept;
  logic                frame_end;
  logic                store_byte;
  logic                ring_step;
  logic                len_clear;
  logic [ADDR_W-1:0]   desc_addr;
  logic [IDX_W-1:0]    ring_idx;
  logic [LEN_W-1:0]    len_cnt;
  logic                len_room;
  logic                len_trunc;
  logic [ADDR_W-1:0]   lane_addr;
  logic [3:0]          lane_be;
  logic [31:0]         lane_wdata;

  assign in_ready   = (state == ST_STORE) || (state == ST_DISCARD);
  assign accept     = in_valid && in_ready;
  assign frame_end  = accept && in_last;
  assign store_byte = (state == ST_STORE) && accept;
  assign ring_step  = (state == ST_WRITEBACK);
  assign len_clear  = (state == ST_LOAD_BUF);
  assign rx_done    = (state == ST_WRITEBACK);
  assign no_buf     = (state == ST_SKIP);

  rxwb_ring_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_base (ring_base),
    .step      (ring_step),
    .wrap      (end_q),
    .desc_addr (desc_addr),
    .idx       (ring_idx)
  );

  rxwb_len_acc u_len (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (len_clear),
    .byte_in (store_byte),
    .cap     (cap_q),
    .cnt     (len_cnt),
    .room    (len_room),
    .trunc   (len_trunc)
  );

  rxwb_byte_lane #(.ADDR_W(ADDR_W)) u_lane (
    .buf_base (buf_q),
    .offset   (len_cnt),
    .data     (in_data),
    .waddr    (lane_addr),
    .be       (lane_be),
    .wdata    (lane_wdata)
  );

  always_comb begin
    nxt       = state;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = '0;
    mem_wdata = '0;
    case (state)
      ST_FETCH_OWN: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr;
        nxt      = ST_CHECK_OWN;
      end
      ST_CHECK_OWN: begin
        if (mem_rdata[OWN_BIT]) begin
          mem_req  = 1'b1;
          mem_addr = desc_addr + OFS_CAP;
          nxt      = ST_LOAD_CAP;
        end else begin
          nxt = ST_DISCARD;
        end
      end
      ST_LOAD_CAP: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + OFS_BUF;
        nxt      = ST_LOAD_BUF;
      end
      ST_LOAD_BUF: nxt = ST_STORE;
      ST_STORE: begin
        if (store_byte && len_room) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = lane_addr;
          mem_be    = lane_be;
          mem_wdata = lane_wdata;
        end
        if (frame_end) nxt = ST_WRITEBACK;
      end
      ST_WRITEBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr;
        mem_be    = 4'hF;
        mem_wdata = status_word(len_cnt, flags_q, len_trunc);
        nxt       = ST_FETCH_OWN;
      end
      ST_DISCARD: if (frame_end) nxt = ST_SKIP;
      ST_SKIP:    nxt = ST_FETCH_OWN;
      default:    nxt = ST_FETCH_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_FETCH_OWN;
      cap_q   <= '0;
      end_q   <= 1'b0;
      buf_q   <= '0;
      flags_q <= '0;
    end else begin
      state <= nxt;
      if (state == ST_LOAD_CAP) begin
        cap_q <= mem_rdata[LEN_W-1:0];
        end_q <= mem_rdata[END_BIT];
      end
      if (state == ST_LOAD_BUF) buf_q <= mem_rdata[ADDR_W-1:0];
      if (store_byte && in_last) flags_q <= in_flags;
    end
  end

  // R7
  done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(frame_end));

  // R8
  nobuf_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_buf |-> $past(frame_end));

  // R8
  discard_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DISCARD || state == ST_SKIP) |-> !mem_we);

  // R3
  one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && state == ST_STORE) |-> ($countones(mem_be) == 1));

  // R10
  no_read_while_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !(mem_req && !mem_we));

  // R2
  own_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD_CAP) |-> $past(mem_rdata[OWN_BIT]));

  // R5
  wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (mem_we && !mem_wdata[OWN_BIT] && mem_addr == desc_addr));

  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done && no_buf));

endmodule

// File: tb/rxwb_engine_bench.sv
module rxwb_engine_bench;
  localparam int ADDR_W = 32;
  localparam int NWORDS = 256;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] ring_base = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [7:0]        in_data = '0;
  logic              in_last = 1'b0;
  logic [6:0]        in_flags = '0;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [3:0]        mem_be;
  logic [31:0]       mem_wdata;
  logic [31:0]       mem_rdata = '0;
  logic              rx_done, no_buf;

  always #4 clk = ~clk;

  rxwb_engine #(.ADDR_W(ADDR_W), .IDX_W(8)) u_rxwb_engine (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_flags(in_flags),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rx_done(rx_done), .no_buf(no_buf)
  );

  logic [31:0] mem     [NWORDS];
  logic [31:0] exp_mem [NWORDS];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // model of the descriptor ring as the bench set it up
  int d_cap [4];
  int d_buf [4];
  bit d_end [4];
  bit d_own [4];
  int mdl_idx = 0;
  int exp_kind = 0;   // 1 = stored, 2 = dropped
  bit pend = 1'b0;

  // memory: read data one cycle after request, byte-lane writes
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[9:2]];
      end
    end
  end

  // acceptance of a final byte, seen at the edge
  always @(posedge clk) begin
    pend = rst_n && in_valid && in_ready && in_last;
    cycles++;
  end

  // per-clock comparison of the pulse outputs against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (rx_done !== (pend && exp_kind == 1)) begin
        fails++;
        $display("FAIL R7 rx_done=%0b expected %0b", rx_done, pend && exp_kind == 1);
      end
      checks++;
      if (no_buf !== (pend && exp_kind == 2)) begin
        fails++;
        $display("FAIL R8 no_buf=%0b expected %0b", no_buf, pend && exp_kind == 2);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 50000 && !finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 50000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", what, act, expv);
    end
  endtask

  task automatic put_word(input int w, input logic [31:0] v);
    mem[w] = v;
    exp_mem[w] = v;
  endtask

  task automatic arm(input int i);
    put_word(i * 4, 32'h8000_0000);
    d_own[i] = 1'b1;
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 5 + 1) & 255);
  endfunction

  task automatic send_frame(input int len, input logic [6:0] fl, input bit gap, input int seed);
    int idx;
    int n;
    int a;
    logic [31:0] st;
    idx = mdl_idx;
    if (d_own[idx]) begin
      exp_kind = 1;
      n = (len < d_cap[idx]) ? len : d_cap[idx];
      for (int i = 0; i < n; i++) begin
        a = d_buf[idx] + i;
        exp_mem[a / 4][8*(a % 4) +: 8] = pat(seed, i);
      end
      st = 32'h3000_0000 | (32'(fl | ((len > d_cap[idx]) ? 7'h10 : 7'h00)) << 16) | 32'(n);
      exp_mem[idx * 4] = st;
      d_own[idx] = 1'b0;
      mdl_idx = d_end[idx] ? 0 : idx + 1;
    end else begin
      exp_kind = 2;
    end
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = pat(seed, i);
      in_last  = (i == len - 1);
      in_flags = (i == len - 1) ? fl : 7'h7F;
      forever begin
        @(posedge clk);
        if (in_ready) break;
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      if (gap && i != len - 1) @(negedge clk);
    end
  endtask

  task automatic check_image(input string what);
    int bad;
    int first;
    bad = 0;
    first = 0;
    for (int w = 0; w < NWORDS; w++)
      if (mem[w] !== exp_mem[w]) begin
        if (bad == 0) first = w;
        bad++;
      end
    check(bad == 0, what, mem[first], exp_mem[first]);
  endtask

  task automatic check_status(input int i);
    check((mem[i*4] & 32'hF000_07FF) === (exp_mem[i*4] & 32'hF000_07FF),
          "R5 status own/segment/length", mem[i*4], exp_mem[i*4]);
    check(mem[i*4][22:16] === exp_mem[i*4][22:16],
          "R6 status flag bits", 32'(mem[i*4][22:16]), 32'(exp_mem[i*4][22:16]));
  endtask

  // run one frame, optionally re-arm a descriptor, then compare memory
  task automatic frame(input int len, input logic [6:0] fl, input bit gap, input int seed,
                       input int rearm, input string img_tag);
    int idx;
    bit stored;
    idx = mdl_idx;
    stored = d_own[idx];
    send_frame(len, fl, gap, seed);
    @(negedge clk);
    if (rearm >= 0) arm(rearm);
    @(negedge clk);
    if (stored) check_status(idx);
    check_image(img_tag);
  endtask

  initial begin
    for (int w = 0; w < NWORDS; w++) put_word(w, 32'h0);
    d_cap = '{32, 32, 6, 20};
    d_buf = '{32'h101, 32'h142, 32'h183, 32'h1C0};
    d_end = '{1'b0, 1'b0, 1'b0, 1'b1};
    for (int i = 0; i < 4; i++) begin
      arm(i);
      put_word(i * 4 + 1, (d_end[i] ? 32'h8000_0000 : 32'h0) | 32'(d_cap[i]));
      put_word(i * 4 + 2, 32'(d_buf[i]));
    end

    // R1 reset state
    repeat (3) @(negedge clk);
    check(!in_ready && !rx_done && !no_buf, "R1 outputs idle in reset",
          {29'b0, in_ready, rx_done, no_buf}, 32'h0);
    check(mem_req && !mem_we && mem_addr == ring_base, "R1 first fetch at ring base",
          mem_addr, ring_base);
    rst_n = 1'b1;

    // R2 fetch sequence latency
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R2 ready low during fetch", 32'(in_ready), 32'h0);
    @(negedge clk);
    check(in_ready == 1'b1, "R2 ready after fetch", 32'(in_ready), 32'h1);

    frame(10, 7'b0000001, 1'b0, 1, 0,  "R3 frame into first descriptor");
    frame(16, 7'b0001010, 1'b1, 2, -1, "R3 gapped frame at lane offset 2");
    frame(9,  7'b0100000, 1'b0, 3, -1, "R4 bytes past capacity discarded");
    frame(20, 7'b1000100, 1'b0, 4, -1, "R4 frame exactly fills capacity");
    frame(5,  7'b0000000, 1'b0, 5, -1, "R9 wrap back to descriptor 0");
    frame(4,  7'b0000011, 1'b0, 6, 1,  "R8 dropped frame writes nothing");
    frame(3,  7'b0001000, 1'b1, 7, -1, "R8 held position reused after arm");
    frame(7,  7'b0000001, 1'b0, 8, -1, "R8 second drop writes nothing");

    // R10 ready after the last drop stays consistent with the fetch
    repeat (4) @(negedge clk);
    check(in_ready == 1'b1, "R10 ready while discarding", 32'(in_ready), 32'h1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule